// File: doc/BRIEF.md
# I2C Bus Phase Timer

This block turns a set of programmed timing words into the cycle-exact shape of the I2C clock line and the strobes a master sequencer needs to move the data line. The sequencer asks for one bus unit at a time: a data bit, a START, or a STOP. The block plays out that unit's phases and then reports that it is ready for the next one. A unit requested in the final cycle of the previous unit follows it with no gap, so the SCL period comes out exactly as programmed.

Each phase length is counted in prescaled ticks, where one tick is DIV+1 input clocks. Every bit closes with a fixed extension of 8 + 2·FILTER input clocks that covers the input glitch filter. A back-to-back bit stream therefore runs at (DIV+1)·(LOW+HIGH+2) + 8 + 2·FILTER clocks per bit. There are two banks of three timing words, one for fast mode and one for high-speed mode. A data-hold word and a configuration word are shared by both banks. The bank is picked by a mode input once per unit.

Top module: `i2c_phase_timer`

## Requirements
- R1: While reset is asserted, and after it is released with no request pending, ready_o and scl_o are 1 and tick_o, drive_o, sample_o, start_o and stop_o are 0.
- R2: A bit unit (op_i = 2'b01) drives scl_o low for (DIV+1)·(LOW+1) clocks, then high for (DIV+1)·(HIGH+1) + 8 + 2·FILTER clocks. Bits issued back to back repeat at exactly that period.
- R3: sample_o pulses for one clock in the first cycle of a bit's high phase, which is the cycle in which scl_o rises.
- R4: drive_o pulses HOLD·(DIV+1) clocks after scl_o falls in a bit, if HOLD ≤ LOW. If HOLD > LOW, it does not pulse in that bit.
- R5: A START (op_i = 2'b10) on a bus that no START has claimed since reset or since the last STOP keeps scl_o high. start_o pulses after (DIV+1)·(STA_SETUP+1) clocks, and the unit then lasts another (DIV+1)·(STA_HOLD+1) clocks.
- R6: A START on a claimed bus is a repeated START. It first drives scl_o low for (DIV+1)·(RELEASE+1) clocks and then continues as in R5.
- R7: A STOP (op_i = 2'b11) drives scl_o low for (DIV+1)·(DAT_SETUP+1) clocks and then high for (DIV+1)·(STO_SETUP+1) clocks. stop_o pulses in the last of those cycles, and the bus becomes unclaimed.
- R8: ready_o is 1 when the block is idle and in the final cycle of each unit. A request on op_i (2'b00 = none) is taken only on a clock where ready_o is 1 and is ignored otherwise.
- R9: hs_i chooses the high-speed bank (1) or the fast bank (0) on the clock where a unit is accepted, and changes to it during a unit have no effect. A START on an unclaimed bus always uses the fast bank.
- R10: Field positions: word0 holds STA_SETUP in [31:24], STA_HOLD in [23:16] and STO_SETUP in [15:8]. word1 holds DAT_SETUP in [31:24], LOW in [15:8] and HIGH in [7:0]. word2 holds DIV in [23:16] and RELEASE in [7:0]. The hold word holds HOLD in [7:0], and the configuration word holds FILTER in [18:16]. All other bits are ignored.
- R11: tick_o pulses once at the end of every prescaled tick of a unit and does not pulse during the filter extension.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Unit request: 00 none, 01 bit, 10 START, 11 STOP |
| hs_i | input | 1 | Bank choice for the requested unit: 1 high-speed, 0 fast |
| fs_word0_i | input | 32 | Fast bank: START setup, START hold, STOP setup |
| fs_word1_i | input | 32 | Fast bank: data setup, SCL low, SCL high |
| fs_word2_i | input | 32 | Fast bank: prescaler divide, repeated-START release |
| hs_word0_i | input | 32 | High-speed bank, same layout as fs_word0_i |
| hs_word1_i | input | 32 | High-speed bank, same layout as fs_word1_i |
| hs_word2_i | input | 32 | High-speed bank, same layout as fs_word2_i |
| hold_word_i | input | 32 | Shared data-hold count |
| conf_word_i | input | 32 | Shared configuration holding the filter count |
| ready_o | output | 1 | A request is taken on this clock |
| scl_o | output | 1 | SCL level to drive (1 = released) |
| tick_o | output | 1 | End of one prescaled tick |
| drive_o | output | 1 | Data line may change now |
| sample_o | output | 1 | Data line is sampled now (SCL rising) |
| start_o | output | 1 | Pull the data line low for START now |
| stop_o | output | 1 | Release the data line for STOP now |

## Verification
The first pattern is a fast-bank run: START, several bits, a repeated START, one more bit and a STOP, all back to back. It shows whether each bit period matches the formula and whether a repeated START is told apart from a first START by its release phase. The same run on the high-speed bank, with hs_i toggling and junk requests on op_i between acceptances, shows whether the bank is latched per unit, whether the first START is forced onto the fast bank, and whether requests that are not ready are dropped. A last set uses minimum LOW and HIGH, a hold longer than LOW, the largest filter count and the largest divider. It separates a drive strobe that falls in the same cycle as the SCL fall from one that is correctly suppressed, and it exercises the extremes of the prescaler.

// File: rtl/i2c_phase_timer_pkg.sv
package i2c_phase_timer_pkg;
  localparam int unsigned FW = 8;  // timing field width

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_BIT   = 2'd1,
    OP_START = 2'd2,
    OP_STOP  = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    PH_IDLE, PH_SR_REL, PH_STA_SU, PH_STA_HD,
    PH_LOW, PH_HIGH, PH_FLT, PH_STO_LOW, PH_STO_SU
  } phase_e;

  typedef struct packed {
    logic [FW-1:0] div;
    logic [FW-1:0] scl_lo;
    logic [FW-1:0] scl_hi;
    logic [FW-1:0] sta_su;
    logic [FW-1:0] sta_hd;
    logic [FW-1:0] sto_su;
    logic [FW-1:0] dat_su;
    logic [FW-1:0] sr_rel;
  } bank_t;
endpackage

// File: rtl/i2c_phase_timer_presc.sv
module i2c_phase_timer_presc
  import i2c_phase_timer_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [FW-1:0] lim_i,
  output logic [FW-1:0] cnt_o,
  output logic          wrap_o
);
  localparam logic [FW-1:0] ONE = FW'(1);

  logic [FW-1:0] cnt_q;

  assign wrap_o = run_i && (cnt_q == lim_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (wrap_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + ONE;
  end
endmodule

// File: rtl/i2c_phase_timer_seq.sv
module i2c_phase_timer_seq
  import i2c_phase_timer_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    op_i,
  input  logic          hs_i,
  input  bank_t         bank_fs_i,
  input  bank_t         bank_hs_i,
  input  logic [FW-1:0] dat_hd_i,
  input  logic [FW-1:0] flt_lim_i,
  input  logic [FW-1:0] pcnt_i,
  input  logic          wrap_i,
  output logic          run_o,
  output logic [FW-1:0] lim_o,
  output logic          ready_o,
  output logic          scl_o,
  output logic          tick_o,
  output logic          drive_o,
  output logic          sample_o,
  output logic          start_o,
  output logic          stop_o
);
  localparam logic [FW-1:0] ONE = FW'(1);

  phase_e        ph_q, ph_first, ph_next;
  logic [FW-1:0] tcnt_q, len;
  bank_t         cfg_q;
  logic [FW-1:0] hd_q, flim_q;
  logic          own_q, own_now, use_hs;
  logic          last, unit_end, accept, entry;
  op_e           op;

  assign op = op_e'(op_i);

  always_comb begin
    unique case (ph_q)
      PH_SR_REL:  len = cfg_q.sr_rel;
      PH_STA_SU:  len = cfg_q.sta_su;
      PH_STA_HD:  len = cfg_q.sta_hd;
      PH_LOW:     len = cfg_q.scl_lo;
      PH_HIGH:    len = cfg_q.scl_hi;
      PH_STO_LOW: len = cfg_q.dat_su;
      PH_STO_SU:  len = cfg_q.sto_su;
      default:    len = '0;
    endcase
  end

  assign last     = wrap_i && (tcnt_q == len);
  assign unit_end = last && (ph_q inside {PH_STA_HD, PH_FLT, PH_STO_SU});
  assign ready_o  = (ph_q == PH_IDLE) || unit_end;
  assign accept   = ready_o && (op != OP_NONE);
  assign own_now  = own_q && !(unit_end && ph_q == PH_STO_SU);
  // a START on a free bus always runs on the fast bank
  assign use_hs   = hs_i && !(op == OP_START && !own_now);

  always_comb begin
    unique case (op)
      OP_START: ph_first = own_now ? PH_SR_REL : PH_STA_SU;
      OP_STOP:  ph_first = PH_STO_LOW;
      default:  ph_first = PH_LOW;
    endcase
  end

  always_comb begin
    unique case (ph_q)
      PH_SR_REL:  ph_next = PH_STA_SU;
      PH_STA_SU:  ph_next = PH_STA_HD;
      PH_LOW:     ph_next = PH_HIGH;
      PH_HIGH:    ph_next = PH_FLT;
      PH_STO_LOW: ph_next = PH_STO_SU;
      default:    ph_next = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      tcnt_q <= '0;
      cfg_q  <= '0;
      hd_q   <= '0;
      flim_q <= '0;
      own_q  <= 1'b0;
    end else if (accept) begin
      ph_q   <= ph_first;
      tcnt_q <= '0;
      cfg_q  <= use_hs ? bank_hs_i : bank_fs_i;
      hd_q   <= dat_hd_i;
      flim_q <= flt_lim_i;
      own_q  <= (op == OP_START) ? 1'b1 : own_now;
    end else if (unit_end) begin
      ph_q   <= PH_IDLE;
      tcnt_q <= '0;
      own_q  <= own_now;
    end else if (last) begin
      ph_q   <= ph_next;
      tcnt_q <= '0;
    end else if (wrap_i) begin
      tcnt_q <= tcnt_q + ONE;
    end
  end

  assign run_o    = (ph_q != PH_IDLE);
  assign lim_o    = (ph_q == PH_FLT) ? flim_q : cfg_q.div;
  assign entry    = (pcnt_i == '0) && (tcnt_q == '0);
  assign scl_o    = !(ph_q inside {PH_SR_REL, PH_LOW, PH_STO_LOW});
  assign tick_o   = wrap_i && (ph_q != PH_FLT);
  assign drive_o  = (ph_q == PH_LOW) && (pcnt_i == '0) && (tcnt_q == hd_q);
  assign sample_o = (ph_q == PH_HIGH) && entry;
  assign start_o  = (ph_q == PH_STA_HD) && entry;
  assign stop_o   = (ph_q == PH_STO_SU) && last;
endmodule

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer
  import i2c_phase_timer_pkg::*;
#(
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned FLT_BASE = 8,
  parameter int unsigned FLT_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        op_i,
  input  logic              hs_i,
  input  logic [WORD_W-1:0] fs_word0_i,
  input  logic [WORD_W-1:0] fs_word1_i,
  input  logic [WORD_W-1:0] fs_word2_i,
  input  logic [WORD_W-1:0] hs_word0_i,
  input  logic [WORD_W-1:0] hs_word1_i,
  input  logic [WORD_W-1:0] hs_word2_i,
  input  logic [WORD_W-1:0] hold_word_i,
  input  logic [WORD_W-1:0] conf_word_i,
  output logic              ready_o,
  output logic              scl_o,
  output logic              tick_o,
  output logic              drive_o,
  output logic              sample_o,
  output logic              start_o,
  output logic              stop_o
);
  localparam int unsigned NBANK      = 2;
  localparam int unsigned STA_SU_LSB = 24;
  localparam int unsigned STA_HD_LSB = 16;
  localparam int unsigned STO_SU_LSB = 8;
  localparam int unsigned DAT_SU_LSB = 24;
  localparam int unsigned SCL_LO_LSB = 8;
  localparam int unsigned SCL_HI_LSB = 0;
  localparam int unsigned DIV_LSB    = 16;
  localparam int unsigned SR_LSB     = 0;
  localparam int unsigned HOLD_LSB   = 0;
  localparam int unsigned FLT_LSB    = 16;

  logic [WORD_W-1:0] w0 [NBANK];
  logic [WORD_W-1:0] w1 [NBANK];
  logic [WORD_W-1:0] w2 [NBANK];
  bank_t             bank [NBANK];

  assign w0[0] = fs_word0_i;
  assign w1[0] = fs_word1_i;
  assign w2[0] = fs_word2_i;
  assign w0[1] = hs_word0_i;
  assign w1[1] = hs_word1_i;
  assign w2[1] = hs_word2_i;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bank[b] = '{
      div:    w2[b][DIV_LSB    +: FW],
      scl_lo: w1[b][SCL_LO_LSB +: FW],
      scl_hi: w1[b][SCL_HI_LSB +: FW],
      sta_su: w0[b][STA_SU_LSB +: FW],
      sta_hd: w0[b][STA_HD_LSB +: FW],
      sto_su: w0[b][STO_SU_LSB +: FW],
      dat_su: w1[b][DAT_SU_LSB +: FW],
      sr_rel: w2[b][SR_LSB     +: FW]
    };
  end

  logic [FLT_W-1:0] flt;
  logic [FW-1:0]    flt_lim, dat_hd, lim, pcnt;
  logic             run, wrap;

  assign flt     = conf_word_i[FLT_LSB +: FLT_W];
  assign flt_lim = FW'(FLT_BASE - 1) + FW'({flt, 1'b0});
  assign dat_hd  = hold_word_i[HOLD_LSB +: FW];

  logic unused_bits;
  assign unused_bits = ^{w0[0][7:0], w0[1][7:0], w1[0][23:16], w1[1][23:16],
                         w2[0][31:24], w2[0][15:8], w2[1][31:24], w2[1][15:8],
                         hold_word_i[WORD_W-1:FW], conf_word_i[WORD_W-1:FLT_LSB+FLT_W],
                         conf_word_i[FLT_LSB-1:0]};

  i2c_phase_timer_presc u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .lim_i  (lim),
    .cnt_o  (pcnt),
    .wrap_o (wrap)
  );

  i2c_phase_timer_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op_i),
    .hs_i      (hs_i),
    .bank_fs_i (bank[0]),
    .bank_hs_i (bank[1]),
    .dat_hd_i  (dat_hd),
    .flt_lim_i (flt_lim),
    .pcnt_i    (pcnt),
    .wrap_i    (wrap),
    .run_o     (run),
    .lim_o     (lim),
    .ready_o   (ready_o),
    .scl_o     (scl_o),
    .tick_o    (tick_o),
    .drive_o   (drive_o),
    .sample_o  (sample_o),
    .start_o   (start_o),
    .stop_o    (stop_o)
  );
endmodule

// File: rtl/i2c_phase_timer_chk.sv
module i2c_phase_timer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ready_o,
  input logic scl_o,
  input logic drive_o,
  input logic sample_o,
  input logic start_o,
  input logic stop_o
);
  p_fall_at_unit_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scl_o) |-> $past(ready_o));

  p_sample_on_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> (scl_o && !$past(scl_o)));

  p_drive_while_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o |-> !scl_o);

  p_start_scl_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (scl_o && $past(scl_o)));

  p_stop_ends_unit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> (scl_o && ready_o));

  p_strobes_exclusive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({drive_o, sample_o, start_o, stop_o}));
endmodule

bind i2c_phase_timer i2c_phase_timer_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ready_o  (ready_o),
  .scl_o    (scl_o),
  .drive_o  (drive_o),
  .sample_o (sample_o),
  .start_o  (start_o),
  .stop_o   (stop_o)
);

// File: tb/i2c_phase_timer_bench.sv
`timescale 1ns/1ps
module i2c_phase_timer_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic        hs_i = 1'b0;
  logic [31:0] fs_word0_i, fs_word1_i, fs_word2_i;
  logic [31:0] hs_word0_i, hs_word1_i, hs_word2_i;
  logic [31:0] hold_word_i, conf_word_i;
  logic ready_o, scl_o, tick_o, drive_o, sample_o, start_o, stop_o;

  always #2 clk_i = ~clk_i;  // 250 MHz

  i2c_phase_timer u_i2c_phase_timer (.*);

  localparam int K_FALL = 0, K_DRIVE = 1, K_RISE = 2, K_SAMPLE = 3, K_START = 4, K_STOP = 5;

  typedef struct {
    int    cyc;
    int    kind;
    string req;
  } ev_t;

  ev_t  exp_q[$];
  int   cyc = 0;
  int   checks = 0, fails = 0;
  bit   done = 1'b0, mon_on = 1'b0, owned = 1'b0;
  int   exp_end = 0, exp_ticks = 0, obs_ticks = 0;
  logic prev_scl = 1'b1;

  int b_div[2], b_lo[2], b_hi[2], b_ssu[2], b_shd[2], b_psu[2], b_dsu[2], b_sr[2];
  int hold_v, flt_v;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic push(int c, int k, string r);
    ev_t e;
    e.cyc = c; e.kind = k; e.req = r;
    exp_q.push_back(e);
  endtask

  // R10: every bit outside the defined fields is driven to one
  task automatic apply_cfg();
    fs_word0_i  = {8'(b_ssu[0]), 8'(b_shd[0]), 8'(b_psu[0]), 8'hFF};
    fs_word1_i  = {8'(b_dsu[0]), 8'hFF, 8'(b_lo[0]), 8'(b_hi[0])};
    fs_word2_i  = {8'hFF, 8'(b_div[0]), 8'hFF, 8'(b_sr[0])};
    hs_word0_i  = {8'(b_ssu[1]), 8'(b_shd[1]), 8'(b_psu[1]), 8'hFF};
    hs_word1_i  = {8'(b_dsu[1]), 8'hFF, 8'(b_lo[1]), 8'(b_hi[1])};
    hs_word2_i  = {8'hFF, 8'(b_div[1]), 8'hFF, 8'(b_sr[1])};
    hold_word_i = {24'hFFFFFF, 8'(hold_v)};
    conf_word_i = {13'h1FFF, 3'(flt_v), 16'hFFFF};
  endtask

  task automatic model(logic [1:0] op, logic hs, int s);
    int b, m, e;
    b = (op == 2'b10 && !owned) ? 0 : int'(hs);
    m = b_div[b] + 1;
    e = 8 + 2 * flt_v;
    case (op)
      2'b01: begin
        push(s, K_FALL, hs ? "R9" : "R2");
        if (hold_v <= b_lo[b]) push(s + hold_v * m, K_DRIVE, "R4");
        push(s + (b_lo[b] + 1) * m, K_RISE, hs ? "R9" : "R2");
        push(s + (b_lo[b] + 1) * m, K_SAMPLE, "R3");
        exp_end = s + (b_lo[b] + b_hi[b] + 2) * m + e - 1;
        exp_ticks += b_lo[b] + b_hi[b] + 2;
      end
      2'b10: begin
        if (!owned) begin
          push(s + (b_ssu[b] + 1) * m, K_START, hs ? "R9" : "R5");
          exp_end = s + (b_ssu[b] + b_shd[b] + 2) * m - 1;
          exp_ticks += b_ssu[b] + b_shd[b] + 2;
        end else begin
          push(s, K_FALL, "R6");
          push(s + (b_sr[b] + 1) * m, K_RISE, "R6");
          push(s + (b_sr[b] + b_ssu[b] + 2) * m, K_START, "R6");
          exp_end = s + (b_sr[b] + b_ssu[b] + b_shd[b] + 3) * m - 1;
          exp_ticks += b_sr[b] + b_ssu[b] + b_shd[b] + 3;
        end
        owned = 1'b1;
      end
      2'b11: begin
        push(s, K_FALL, "R7");
        push(s + (b_dsu[b] + 1) * m, K_RISE, "R7");
        push(s + (b_dsu[b] + b_psu[b] + 2) * m - 1, K_STOP, "R7");
        exp_end = s + (b_dsu[b] + b_psu[b] + 2) * m - 1;
        exp_ticks += b_dsu[b] + b_psu[b] + 2;
        owned = 1'b0;
      end
      default: ;
    endcase
  endtask

  // driver: junk on op_i/hs_i while not ready (R8, R9), then the real request
  task automatic do_op(logic [1:0] op, logic hs, bit b2b);
    forever begin
      @(negedge clk_i);
      if (ready_o) break;
      op_i = {1'b1, cyc[0]};
      hs_i = ~hs_i;
    end
    if (b2b) check(cyc == exp_end, "R8 R10", "ready cycle of back-to-back unit", cyc, exp_end);
    op_i = op;
    hs_i = hs;
    model(op, hs, cyc + 1);
  endtask

  task automatic settle();
    @(negedge clk_i);
    op_i = 2'b00;
    while (!ready_o) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
  endtask

  task automatic expect_ev(int kind);
    ev_t e;
    if (exp_q.size() == 0) begin
      check(1'b0, "R8", "unexpected strobe kind", kind, -1);
    end else begin
      e = exp_q.pop_front();
      check(e.kind == kind, e.req, "strobe kind", kind, e.kind);
      check(e.cyc == cyc, e.req, "strobe cycle", cyc, e.cyc);
    end
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (mon_on) begin
      if (prev_scl && !scl_o) expect_ev(K_FALL);
      if (drive_o)            expect_ev(K_DRIVE);
      if (!prev_scl && scl_o) expect_ev(K_RISE);
      if (sample_o)           expect_ev(K_SAMPLE);
      if (start_o)            expect_ev(K_START);
      if (stop_o)             expect_ev(K_STOP);
      if (tick_o)             obs_ticks++;
      prev_scl = scl_o;
    end
  end

  task automatic check_reset_state(string what);
    check(ready_o === 1'b1, "R1", {what, " ready_o"}, int'(ready_o), 1);
    check(scl_o === 1'b1, "R1", {what, " scl_o"}, int'(scl_o), 1);
    check({tick_o, drive_o, sample_o, start_o, stop_o} === 5'b0, "R1", {what, " strobes"},
          int'({tick_o, drive_o, sample_o, start_o, stop_o}), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      check(1'b0, "R8", "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    b_div = '{1, 0}; b_lo = '{3, 2}; b_hi = '{2, 1};
    b_ssu = '{2, 1}; b_shd = '{1, 2}; b_psu = '{2, 1};
    b_dsu = '{1, 0}; b_sr = '{3, 1};
    hold_v = 1; flt_v = 1;
    apply_cfg();
    repeat (3) @(negedge clk_i);
    check_reset_state("in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_reset_state("after reset");
    mon_on = 1'b1;

    // fast bank: START, bits, repeated START, bit, STOP (R2 R3 R4 R5 R6 R7)
    do_op(2'b10, 1'b0, 1'b0);
    do_op(2'b01, 1'b0, 1'b1);
    do_op(2'b01, 1'b0, 1'b1);
    do_op(2'b01, 1'b0, 1'b1);
    do_op(2'b10, 1'b0, 1'b1);
    do_op(2'b01, 1'b0, 1'b1);
    do_op(2'b11, 1'b0, 1'b1);
    settle();

    // high-speed bank with first START forced to fast (R9)
    do_op(2'b10, 1'b1, 1'b0);
    do_op(2'b01, 1'b1, 1'b1);
    do_op(2'b01, 1'b1, 1'b1);
    do_op(2'b10, 1'b1, 1'b1);
    do_op(2'b01, 1'b0, 1'b1);
    do_op(2'b11, 1'b1, 1'b1);
    settle();

    // minimum low/high, hold of zero, largest filter (R2 R4)
    b_div[0] = 3; b_lo[0] = 0; b_hi[0] = 0; hold_v = 0; flt_v = 7;
    apply_cfg();
    do_op(2'b01, 1'b0, 1'b0);
    do_op(2'b01, 1'b0, 1'b1);
    settle();

    // hold beyond low time suppresses drive (R4)
    hold_v = 5;
    apply_cfg();
    do_op(2'b01, 1'b0, 1'b0);
    do_op(2'b01, 1'b1, 1'b1);
    settle();

    // largest divider (R2 R11)
    b_div[0] = 255; b_lo[0] = 1; b_hi[0] = 1; hold_v = 1; flt_v = 0;
    apply_cfg();
    do_op(2'b01, 1'b0, 1'b0);
    do_op(2'b11, 1'b0, 1'b1);
    settle();

    check(exp_q.size() == 0, "R2", "expected strobes never seen", exp_q.size(), 0);
    check(obs_ticks == exp_ticks, "R11", "prescaled tick count", obs_ticks, exp_ticks);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule